// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital side of an 8-bit successive-approximation analog-to-digital converter. It sits on a simple microcontroller register bus and has two registers. The control register picks one of eight analog channels, switches the reference ladder current, enables a hardware trigger and selects the interrupt source. The result register is read-only and holds the last completed conversion.

A conversion starts in one of two ways: software writes the control register with the completion bit at 0, or, when enabled, the synchronized external trigger input falls. The controller then runs a binary search from the most significant bit down. In each of eight cycles it drives a trial code to an external resistor-ladder DAC and samples a one-bit comparator. When the search ends, the result is stored, the completion bit is set, and an interrupt pulse can be raised. The analog ladder, multiplexer and comparator sit outside the block. The block sees them only through the channel-select, ladder-enable, code and comparator pins.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Control bits 2:0 hold the channel number, 000 for channel 0 through 111 for channel 7. They read back unchanged and drive `chan_sel`.
- R2: Control bit 3 is the completion flag. It reads 0 from the clock edge that accepts a start, and reads 1 after the eighth trial edge that follows.
- R3: A control write (`addr`=0) with `wdata[3]`=0 starts a conversion. A control write with `wdata[3]`=1 starts nothing and leaves bit 3 unchanged.
- R4: Control bit 4 drives `ladder_en` (1 = ladder current on).
- R5: With control bit 5 at 1, a falling edge on `ext_trig` starts a conversion after a two-flop synchronizer. With bit 5 at 0, the edge starts nothing and the result stays unchanged.
- R6: With control bit 6 at 0, `irq` is a single-cycle pulse raised once per completed conversion.
- R7: With control bit 6 at 1, `irq` pulses once for each falling edge of `ext_trig` and does not pulse at completion.
- R8: Control bit 7 is unused and always reads 0.
- R9: The result register (`addr`=1) is read-only. Writes to it are ignored. During a conversion it returns the previous result, and it changes only at completion.
- R10: The search tests bits from MSB to LSB. It keeps a bit when `cmp_in` is 1, meaning the input is at or above `dac_code`. The result equals the largest code the comparator accepts.
- R11: A start that arrives during a conversion restarts the search from the MSB. The abandoned conversion neither completes nor updates the result.
- R12: After reset the control register, the result, `irq` and `dac_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 result |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| ext_trig | input | 1 | External trigger, active on its falling edge |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | 8 | Trial code to the ladder DAC, 0 when idle |
| chan_sel | output | 3 | Analog channel select |
| ladder_en | output | 1 | Reference ladder current switch |
| irq | output | 1 | Interrupt request pulse |

## Verification
The search is run against a modelled comparator for every one of the 256 input levels. This tells apart a bit that is wrongly kept from one that is wrongly dropped, and it covers both end codes. Trials with cycle-exact sampling separate a completion that comes one edge early or late from a correct one. A restart halfway through shows whether the abandoned search leaks into the result. Trigger patterns are run with the enable on and off and with both interrupt sources. These show whether the edge path and the completion path are each gated by the right control bit.

// File: rtl/sar_pkg.sv
package sar_pkg;
  parameter int unsigned RES_W  = 8;
  parameter int unsigned CHAN_W = 3;
  parameter int unsigned DATA_W = 8;

  // control register bit positions
  localparam int unsigned BIT_DONE = CHAN_W;
  localparam int unsigned BIT_LAD  = CHAN_W + 1;
  localparam int unsigned BIT_EXT  = CHAN_W + 2;
  localparam int unsigned BIT_SRC  = CHAN_W + 3;

  typedef enum logic {
    REG_CTRL   = 1'b0,
    REG_RESULT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_out_n = out_q;
endmodule

// File: rtl/sar_trig_sync.sv
module sar_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic fall
);
  logic meta_q, sync_q, prev_q;
  logic meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = trig_in;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall = prev_q & ~sync_q;

  // R7
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int unsigned RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_in,
  output logic             busy,
  output logic [RES_W-1:0] trial_code,
  output logic             fin,
  output logic [RES_W-1:0] final_val
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic             busy_q, busy_d;
  logic [RES_W-1:0] mask_q, mask_d;
  logic [RES_W-1:0] acc_q, acc_d;
  logic             step_en;

  assign step_en = start | busy_q;

  always_comb begin
    busy_d = busy_q;
    mask_d = mask_q;
    acc_d  = acc_q;
    if (start) begin
      busy_d = 1'b1;
      mask_d = TOP_BIT;
      acc_d  = '0;
    end else if (busy_q) begin
      if (cmp_in) acc_d = acc_q | mask_q;
      mask_d = mask_q >> 1;
      if (mask_q[0]) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mask_q <= '0;
      acc_q  <= '0;
    end else if (step_en) begin
      busy_q <= busy_d;
      mask_q <= mask_d;
      acc_q  <= acc_d;
    end
  end

  assign busy       = busy_q;
  assign trial_code = busy_q ? (acc_q | mask_q) : '0;
  assign fin        = busy_q & mask_q[0] & ~start;
  assign final_val  = cmp_in ? (acc_q | mask_q) : acc_q;

  // R10
  mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $onehot0(mask_q) && (mask_q != '0));

  // R11
  restart_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q && mask_q == TOP_BIT);
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_trig,
  input  logic              cmp_in,
  output logic [RES_W-1:0]  dac_code,
  output logic [CHAN_W-1:0] chan_sel,
  output logic              ladder_en,
  output logic              irq
);
  localparam int unsigned PAD_W = DATA_W - (CHAN_W + 4);

  logic rst_s_n;
  logic ext_fall;

  logic [CHAN_W-1:0] chan_q, chan_d;
  logic done_q, done_d;
  logic lad_q, lad_d;
  logic ext_q, ext_d;
  logic src_q, src_d;
  logic [RES_W-1:0] res_q, res_d;
  logic irq_q, irq_d;

  logic ctrl_wr, sw_start, conv_start;
  logic busy, fin;
  logic [RES_W-1:0] final_val;

  sar_rst_sync u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_s_n)
  );

  sar_trig_sync u_trig (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .trig_in (ext_trig),
    .fall    (ext_fall)
  );

  sar_engine #(.RES_W(RES_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .start      (conv_start),
    .cmp_in     (cmp_in),
    .busy       (busy),
    .trial_code (dac_code),
    .fin        (fin),
    .final_val  (final_val)
  );

  assign ctrl_wr    = wr_en & (addr == REG_CTRL);
  assign sw_start   = ctrl_wr & ~wdata[BIT_DONE];
  assign conv_start = sw_start | (ext_q & ext_fall);

  always_comb begin
    chan_d = chan_q;
    lad_d  = lad_q;
    ext_d  = ext_q;
    src_d  = src_q;
    if (ctrl_wr) begin
      chan_d = wdata[CHAN_W-1:0];
      lad_d  = wdata[BIT_LAD];
      ext_d  = wdata[BIT_EXT];
      src_d  = wdata[BIT_SRC];
    end
    done_d = done_q;
    if (conv_start)  done_d = 1'b0;
    else if (fin)    done_d = 1'b1;
    res_d = fin ? final_val : res_q;
    irq_d = src_q ? ext_fall : fin;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      chan_q <= '0;
      done_q <= 1'b0;
      lad_q  <= 1'b0;
      ext_q  <= 1'b0;
      src_q  <= 1'b0;
      res_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      chan_q <= chan_d;
      done_q <= done_d;
      lad_q  <= lad_d;
      ext_q  <= ext_d;
      src_q  <= src_d;
      if (fin) res_q <= res_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    if (addr == REG_RESULT) rdata = res_q;
    else rdata = {{PAD_W{1'b0}}, src_q, ext_q, lad_q, done_q, chan_q};
  end

  assign chan_sel  = chan_q;
  assign ladder_en = lad_q;
  assign irq       = irq_q;

  // R2
  busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy |-> !done_q);

  // R3
  sw_start_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    sw_start |=> busy && !done_q);

  // R5
  ext_ignored_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy && ext_fall && !ext_q && !sw_start) |=> !busy);

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_q |=> !irq_q);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !fin |=> $stable(res_q));
endmodule

// File: tb/sar_adc_ctrl_test.sv
`timescale 1ns/1ps
module sar_adc_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ext_trig = 1'b1;
  logic       cmp_in;
  logic [7:0] dac_code;
  logic [2:0] chan_sel;
  logic       ladder_en;
  logic       irq;

  logic [7:0] vin = 8'h00;
  int tests = 0;
  int fails = 0;
  int irq_cnt = 0;
  logic [7:0] saved;
  int snap;
  bit ended = 0;

  always #2 clk = ~clk;

  assign cmp_in = (vin >= dac_code);

  sar_adc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_trig(ext_trig), .cmp_in(cmp_in), .dac_code(dac_code),
    .chan_sel(chan_sel), .ladder_en(ladder_en), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_ctrl(output logic [7:0] v);
    addr = 1'b0; #0.1 v = rdata;
  endtask

  task automatic read_res(output logic [7:0] v);
    addr = 1'b1; #0.1 v = rdata; addr = 1'b0;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] r;
    int got;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);

    // R12 reset state
    read_ctrl(v);
    check(v == 8'h00, "R12 ctrl", v, 0);
    read_res(v);
    check(v == 8'h00, "R12 result", v, 0);
    check(irq == 0 && dac_code == 0, "R12 irq/code", {irq, dac_code}, 0);

    // R1, R8, R4: channel sweep with ladder bit toggling
    for (int c = 0; c < 8; c++) begin
      wr(1'b0, 8'h88 | 8'(c) | ((c % 2) ? 8'h10 : 8'h00));
      read_ctrl(v);
      check(chan_sel == 3'(c) && v[2:0] == 3'(c), "R1 channel", chan_sel, c);
      check(v[7] == 1'b0, "R8 bit7", v[7], 0);
      check(ladder_en == 1'(c % 2), "R4 ladder", ladder_en, c % 2);
    end

    // R10 exhaustive search, with R2 timing on every level
    for (int lvl = 0; lvl < 256; lvl++) begin
      vin = 8'(lvl);
      wr(1'b0, 8'h00);
      cycles(7);
      read_ctrl(v);
      if (v[3] != 1'b0) check(0, "R2 early done", v[3], 0);
      cycles(1);
      read_ctrl(v);
      check(v[3] == 1'b1, "R2 done set", v[3], 1);
      read_res(r);
      check(r == 8'(lvl), "R10 result", r, lvl);
    end

    // R6 irq once per conversion, src=0
    snap = irq_cnt;
    vin = 8'h3C;
    wr(1'b0, 8'h00);
    cycles(12);
    check(irq_cnt - snap == 1, "R6 irq count", irq_cnt - snap, 1);

    // R9 previous result during conversion, write to result ignored
    read_res(saved);
    wr(1'b1, 8'hA5);
    read_res(r);
    check(r == saved, "R9 write ignored", r, saved);
    vin = 8'hC3;
    wr(1'b0, 8'h00);
    cycles(4);
    read_res(r);
    check(r == saved, "R9 hold during conv", r, saved);
    cycles(6);
    read_res(r);
    check(r == 8'hC3, "R9 updated", r, 8'hC3);

    // R3 write with bit3=1 starts nothing
    vin = 8'h11;
    wr(1'b0, 8'h08);
    cycles(12);
    read_res(r);
    read_ctrl(v);
    check(r == 8'hC3 && v[3] == 1'b1, "R3 no start", r, 8'hC3);

    // R11 restart mid-conversion
    snap = irq_cnt;
    vin = 8'h5A;
    wr(1'b0, 8'h00);
    cycles(3);
    vin = 8'hA7;
    wr(1'b0, 8'h00);
    cycles(5);
    read_ctrl(v);
    check(v[3] == 1'b0, "R11 no early finish", v[3], 0);
    cycles(4);
    read_res(r);
    check(r == 8'hA7, "R11 restart result", r, 8'hA7);
    check(irq_cnt - snap == 1, "R11 single irq", irq_cnt - snap, 1);

    // R5 ignored when disabled
    vin = 8'h22;
    @(negedge clk) ext_trig = 1'b0;
    cycles(20);
    ext_trig = 1'b1;
    cycles(4);
    read_res(r);
    read_ctrl(v);
    check(r == 8'hA7 && v[3] == 1'b1, "R5 ignored", r, 8'hA7);

    // R5 enabled
    wr(1'b0, 8'h28);
    vin = 8'h77;
    @(negedge clk) ext_trig = 1'b0;
    got = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      read_ctrl(v);
      if (v[3] == 1'b0) got = 1;
    end
    ext_trig = 1'b1;
    cycles(4);
    read_res(r);
    check(got == 1 && r == 8'h77, "R5 ext start", r, 8'h77);

    // R7 src=1: irq on falling edge only
    wr(1'b0, 8'h48);
    snap = irq_cnt;
    @(negedge clk) ext_trig = 1'b0;
    cycles(8);
    ext_trig = 1'b1;
    cycles(4);
    check(irq_cnt - snap == 1, "R7 edge irq", irq_cnt - snap, 1);
    snap = irq_cnt;
    wr(1'b0, 8'h40);
    cycles(12);
    check(irq_cnt - snap == 0, "R7 no completion irq", irq_cnt - snap, 0);

    finish_run();
  end
endmodule